// File: doc/BRIEF.md
# SIMD Doubleword Element-Reverse Unit

This block executes a single vector instruction: it reverses the order of
the elements held inside each 64-bit container of a source register and
writes the result to a destination register. It takes a 32-bit instruction
word, together with a flag that picks one of two encoding sets: the plain
32-bit set or the mixed 16/32-bit set. From the word it decodes the
register numbers, the element width (8, 16 or 32 bits) and whether one
64-bit register or a 128-bit pair of registers is processed.

Operands live in an internal bank of 32 registers of 64 bits each. A host
port preloads any register and reads any register back. When the word is
not a legal form of the instruction, the block raises a one-cycle
undefined flag and writes nothing. The block has no condition flags. It
neither reads nor changes any.

Top module: `vrev_unit`

## Requirements
- R1: A word is accepted only when all of these fields hold: bits 21:20 = 11, bits 17:16 = 00, bits 11:7 = 00000 and bit 4 = 0. Bits 31:23 must also be 111100111 when `mixed_set_i` = 0, and 111111111 when `mixed_set_i` = 1. Any other word raises `undef_o` for one cycle and writes no register.
- R2: Bits 19:18 select the element width: 00 selects 8 bits, 01 selects 16 bits and 10 selects 32 bits. Within each 64-bit container, element k of the source is moved to position N-1-k, where N is 8, 4 or 2. The source register is left unchanged when it is not also the destination.
- R3: A size field of 11 raises `undef_o` for one cycle and leaves every register unchanged.
- R4: When bit 6 = 1, an odd destination number or an odd source number raises `undef_o` for one cycle and writes nothing.
- R5: When bit 6 = 1, registers s and s+1 are reversed separately into d and d+1. No element crosses between the two halves. When bit 6 = 0, only register d is written.
- R6: The destination number is {bit 22, bits 15:12} and the source number is {bit 5, bits 3:0}.
- R7: `valid_i` is sampled at a rising edge. For a legal word, `busy_o` is high for 1 cycle (64-bit form) or 2 cycles (128-bit form) after that edge, and the block writes one register per cycle. `done_o` is then high for exactly one cycle, and the written data can be read in that cycle. For an illegal word, `undef_o` is high in the cycle after the edge and `busy_o` stays low.
- R8: All source data is captured at the accepting edge. When the destination pair overlaps the source pair, the result still equals the reversal of the original values.
- R9: `valid_i` is ignored while `busy_o` is high.
- R10: A host write with `host_we_i` = 1 updates register `host_waddr_i` at the clock edge. `host_rdata_o` shows register `host_raddr_i` combinationally.
- R11: After reset, every register reads zero and `busy_o`, `done_o` and `undef_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| mixed_set_i | input | 1 | 1 selects the mixed 16/32-bit encoding set |
| host_we_i | input | 1 | Host register write enable |
| host_waddr_i | input | 5 | Host write register number |
| host_wdata_i | input | 64 | Host write data |
| host_raddr_i | input | 5 | Host read register number |
| host_rdata_o | output | 64 | Host read data |
| busy_o | output | 1 | Write-back in progress |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | One-cycle undefined-encoding pulse |

## Verification
A wrong element permutation, or a lost source capture, shows up as a wrong
register value on the host read port in the same cycle that `done_o` rises.
A sequencing fault is visible on `busy_o` and `done_o` one or two cycles
after the strobe. Such faults include an extra write beat, a stuck beat
counter, and acceptance while busy. A stray write by a rejected word
changes the read data one cycle later. The bench detects it by reading back
the destination register and comparing it with the value it held before.

// File: rtl/vrev_pkg.sv
package vrev_pkg;
   localparam int REG_AW = 5;

   typedef enum logic [1:0] {
      ESZ_8   = 2'b00,
      ESZ_16  = 2'b01,
      ESZ_32  = 2'b10,
      ESZ_BAD = 2'b11
   } esz_t;

   typedef struct packed {
      logic              legal;
      logic              wide;
      esz_t              esz;
      logic [REG_AW-1:0] dst;
      logic [REG_AW-1:0] src;
   } dec_t;
endpackage

// File: rtl/vrev_decode.sv
module vrev_decode
   import vrev_pkg::*;
(
   input  logic [31:0] instr,
   input  logic        mixed_set,
   output dec_t        dec
);
   logic [8:0] want_hi;
   logic       shape_ok;
   logic       size_ok;
   logic       pair_ok;

   always_comb begin
      want_hi  = mixed_set ? 9'b111111111 : 9'b111100111;
      shape_ok = (instr[31:23] == want_hi) && (instr[21:20] == 2'b11) &&
                 (instr[17:16] == 2'b00) && (instr[11:7] == 5'b00000) &&
                 (instr[4] == 1'b0);
      dec.esz  = esz_t'(instr[19:18]);
      dec.wide = instr[6];
      dec.dst  = {instr[22], instr[15:12]};
      dec.src  = {instr[5], instr[3:0]};
      size_ok  = (dec.esz != ESZ_BAD);
      pair_ok  = !dec.wide || (!dec.dst[0] && !dec.src[0]);
      dec.legal = shape_ok && size_ok && pair_ok;
   end
endmodule

// File: rtl/vrev_permute.sv
module vrev_permute
   import vrev_pkg::*;
#(
   parameter int CW = 64
) (
   input  logic [CW-1:0] din,
   input  esz_t          esz,
   output logic [CW-1:0] dout
);
   localparam int NSZ = 3;

   logic [CW-1:0] cand [NSZ];

   for (genvar g = 0; g < NSZ; g++) begin : g_size
      localparam int EW = 8 << g;
      localparam int NE = CW / EW;
      logic [CW-1:0] r;
      always_comb begin
         r = '0;
         for (int k = 0; k < NE; k++) begin
            r[(NE-1-k)*EW +: EW] = din[k*EW +: EW];
         end
      end
      assign cand[g] = r;
   end

   always_comb begin
      unique case (esz)
         ESZ_8:   dout = cand[0];
         ESZ_16:  dout = cand[1];
         ESZ_32:  dout = cand[2];
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/vrev_regbank.sv
module vrev_regbank #(
   parameter int NREGS = 32,
   parameter int CW    = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we_a,
   input  logic [$clog2(NREGS)-1:0] addr_a,
   input  logic [CW-1:0]            data_a,
   input  logic                     we_b,
   input  logic [$clog2(NREGS)-1:0] addr_b,
   input  logic [CW-1:0]            data_b,
   input  logic [$clog2(NREGS)-1:0] raddr0,
   input  logic [$clog2(NREGS)-1:0] raddr1,
   input  logic [$clog2(NREGS)-1:0] raddr_h,
   output logic [CW-1:0]            rdata0,
   output logic [CW-1:0]            rdata1,
   output logic [CW-1:0]            rdata_h
);
   localparam int AW = $clog2(NREGS);

   logic [CW-1:0] mem [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem[i] <= '0;
         end else if (we_b && (addr_b == AW'(i))) begin
            mem[i] <= data_b;
         end else if (we_a && (addr_a == AW'(i))) begin
            mem[i] <= data_a;
         end
      end
   end

   assign rdata0  = mem[raddr0];
   assign rdata1  = mem[raddr1];
   assign rdata_h = mem[raddr_h];
endmodule

// File: rtl/vrev_unit.sv
module vrev_unit
   import vrev_pkg::*;
#(
   parameter int CW    = 64,
   parameter int NREGS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [31:0]       instr_i,
   input  logic              mixed_set_i,
   input  logic              host_we_i,
   input  logic [REG_AW-1:0] host_waddr_i,
   input  logic [CW-1:0]     host_wdata_i,
   input  logic [REG_AW-1:0] host_raddr_i,
   output logic [CW-1:0]     host_rdata_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              undef_o
);
   localparam int NBEATS = 2;

   if (CW != 64) begin : g_bad_cw
      $error("vrev_unit: CW must be 64");
   end
   if (NREGS != (1 << REG_AW)) begin : g_bad_nregs
      $error("vrev_unit: NREGS must match the 5-bit register field");
   end

   typedef enum logic {ST_IDLE, ST_WRITE} state_t;

   state_t            state;
   dec_t              dec;
   logic [CW-1:0]     src_raw [NBEATS];
   logic [CW-1:0]     src_rev [NBEATS];
   logic [CW-1:0]     hold    [NBEATS];
   logic [REG_AW-1:0] dst_q;
   logic              wide_q;
   logic              beat;
   logic              exec_we;
   logic [REG_AW-1:0] exec_addr;
   logic [CW-1:0]     exec_data;
   logic              accept;

   vrev_decode u_dec (
      .instr     (instr_i),
      .mixed_set (mixed_set_i),
      .dec       (dec)
   );

   for (genvar b = 0; b < NBEATS; b++) begin : g_lane
      vrev_permute #(.CW(CW)) u_perm (
         .din  (src_raw[b]),
         .esz  (dec.esz),
         .dout (src_rev[b])
      );
   end

   assign exec_we   = (state == ST_WRITE);
   assign exec_addr = {dst_q[REG_AW-1:1], dst_q[0] | beat};
   assign exec_data = beat ? hold[1] : hold[0];
   assign accept    = valid_i && (state == ST_IDLE);

   vrev_regbank #(.NREGS(NREGS), .CW(CW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_a    (host_we_i),
      .addr_a  (host_waddr_i),
      .data_a  (host_wdata_i),
      .we_b    (exec_we),
      .addr_b  (exec_addr),
      .data_b  (exec_data),
      .raddr0  (dec.src),
      .raddr1  ({dec.src[REG_AW-1:1], 1'b1}),
      .raddr_h (host_raddr_i),
      .rdata0  (src_raw[0]),
      .rdata1  (src_raw[1]),
      .rdata_h (host_rdata_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         dst_q   <= '0;
         wide_q  <= 1'b0;
         beat    <= 1'b0;
         done_o  <= 1'b0;
         undef_o <= 1'b0;
         hold[0] <= '0;
         hold[1] <= '0;
      end else begin
         done_o  <= 1'b0;
         undef_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (!dec.legal) begin
                     undef_o <= 1'b1;
                  end else begin
                     hold[0] <= src_rev[0];
                     hold[1] <= src_rev[1];
                     dst_q   <= dec.dst;
                     wide_q  <= dec.wide;
                     beat    <= 1'b0;
                     state   <= ST_WRITE;
                  end
               end
            end
            ST_WRITE: begin
               if (beat == wide_q) begin
                  state  <= ST_IDLE;
                  done_o <= 1'b1;
               end else begin
                  beat <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state == ST_WRITE);
endmodule

// File: rtl/vrev_unit_chk.sv
module vrev_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        valid_i,
   input logic        host_we_i,
   input logic [4:0]  host_raddr_i,
   input logic [63:0] host_rdata_o,
   input logic        busy_o,
   input logic        done_o,
   input logic        undef_o
);
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));

   p_undef_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      undef_o |-> (!busy_o && !done_o && $past(valid_i)));

   p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |=> !busy_o);

   // R3 / R4: with no write-back beat and no host write, the bank stays still
   p_bank_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !host_we_i) |=> ($stable(host_raddr_i) -> $stable(host_rdata_o)));
endmodule

bind vrev_unit vrev_unit_chk i_chk (.*);

// File: tb/test_vrev_unit.sv
`timescale 1ns/1ps
module test_vrev_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic        mixed_set_i = 1'b0;
   logic        host_we_i = 1'b0;
   logic [4:0]  host_waddr_i = '0;
   logic [63:0] host_wdata_i = '0;
   logic [4:0]  host_raddr_i = '0;
   logic [63:0] host_rdata_o;
   logic        busy_o, done_o, undef_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   vrev_unit i_vrev_unit (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit mx, input logic [4:0] d,
                                      input logic [4:0] m, input logic [1:0] sz,
                                      input bit q);
      logic [8:0] hi;
      hi = mx ? 9'b111111111 : 9'b111100111;
      return {hi, d[4], 2'b11, sz, 2'b00, d[3:0], 5'b00000, q, m[4], 1'b0, m[3:0]};
   endfunction

   function automatic logic [63:0] rv(input logic [63:0] x, input logic [1:0] sz);
      logic [63:0] r;
      r = x;
      case (sz)
         2'b00: for (int k = 0; k < 8; k++) r[(7-k)*8 +: 8] = x[k*8 +: 8];
         2'b01: for (int k = 0; k < 4; k++) r[(3-k)*16 +: 16] = x[k*16 +: 16];
         2'b10: for (int k = 0; k < 2; k++) r[(1-k)*32 +: 32] = x[k*32 +: 32];
         default: r = x;
      endcase
      return r;
   endfunction

   task automatic hwrite(input logic [4:0] a, input logic [63:0] v);
      @(negedge clk);
      host_we_i = 1'b1; host_waddr_i = a; host_wdata_i = v;
      @(negedge clk);
      host_we_i = 1'b0;
   endtask

   task automatic hread(input logic [4:0] a, output logic [63:0] v);
      host_raddr_i = a;
      #0.1;
      v = host_rdata_o;
   endtask

   // nbusy: 0 = undefined expected, 1 or 2 = write-back cycles expected
   task automatic op(input logic [31:0] ins, input bit mx, input int nbusy,
                     input string req);
      @(negedge clk);
      valid_i = 1'b1; instr_i = ins; mixed_set_i = mx;
      @(negedge clk);
      valid_i = 1'b0;
      if (nbusy == 0) begin
         chk(undef_o && !busy_o, {req, " undef pulse"}, {62'd0, undef_o, busy_o}, 64'd2);
         @(negedge clk);
         chk(!undef_o && !busy_o && !done_o, {req, " undef one cycle"},
             {61'd0, undef_o, busy_o, done_o}, 64'd0);
      end else begin
         chk(!undef_o && busy_o && !done_o, {req, " R7 busy first"},
             {61'd0, undef_o, busy_o, done_o}, 64'd2);
         if (nbusy == 2) begin
            @(negedge clk);
            chk(busy_o && !done_o, {req, " R7 busy second"},
                {62'd0, busy_o, done_o}, 64'd2);
         end
         @(negedge clk);
         chk(done_o && !busy_o, {req, " R7 done"}, {62'd0, busy_o, done_o}, 64'd1);
      end
   endtask

   task automatic done_gone(input string req);
      @(negedge clk);
      chk(!done_o, {req, " R7 done one cycle"}, {63'd0, done_o}, 64'd0);
   endtask

   task automatic t_reset;
      logic [63:0] v;
      chk(!busy_o && !done_o && !undef_o, "R11 outputs", {61'd0, busy_o, done_o, undef_o}, 64'd0);
      hread(5'd5, v);  chk(v == 64'd0, "R11 reg5", v, 64'd0);
      hread(5'd31, v); chk(v == 64'd0, "R11 reg31", v, 64'd0);
   endtask

   task automatic t_host;
      logic [63:0] v;
      hwrite(5'd7, 64'hDEAD_BEEF_0123_4567);
      hread(5'd7, v);
      chk(v == 64'hDEAD_BEEF_0123_4567, "R10 host rw", v, 64'hDEAD_BEEF_0123_4567);
   endtask

   task automatic t_sizes;
      logic [63:0] v;
      logic [63:0] src;
      src = 64'h0706_0504_0302_0100;
      hwrite(5'd19, src);
      for (int s = 0; s < 3; s++) begin
         op(mk(1'b0, 5'd17, 5'd19, 2'(s), 1'b0), 1'b0, 1, "R2");
         hread(5'd17, v);
         chk(v == rv(src, 2'(s)), "R2 R6 reversed value", v, rv(src, 2'(s)));
         done_gone("R2");
         hread(5'd19, v);
         chk(v == src, "R2 source intact", v, src);
      end
   endtask

   task automatic t_wide;
      logic [63:0] v;
      hwrite(5'd6, 64'h1111_2222_3333_4444);
      hwrite(5'd7, 64'hAAAA_BBBB_CCCC_DDDD);
      hwrite(5'd22, 64'h5A5A_5A5A_5A5A_5A5A);
      op(mk(1'b0, 5'd20, 5'd6, 2'b01, 1'b1), 1'b0, 2, "R5");
      hread(5'd20, v);
      chk(v == 64'h4444_3333_2222_1111, "R5 low half", v, 64'h4444_3333_2222_1111);
      hread(5'd21, v);
      chk(v == 64'hDDDD_CCCC_BBBB_AAAA, "R5 high half", v, 64'hDDDD_CCCC_BBBB_AAAA);
      hread(5'd22, v);
      chk(v == 64'h5A5A_5A5A_5A5A_5A5A, "R5 neighbour untouched", v, 64'h5A5A_5A5A_5A5A_5A5A);
      done_gone("R5");
   endtask

   task automatic t_overlap;
      logic [63:0] v;
      hwrite(5'd10, 64'h0011_2233_4455_6677);
      hwrite(5'd11, 64'h8899_AABB_CCDD_EEFF);
      op(mk(1'b0, 5'd10, 5'd10, 2'b00, 1'b1), 1'b0, 2, "R8");
      hread(5'd10, v);
      chk(v == 64'h7766_5544_3322_1100, "R8 in place low", v, 64'h7766_5544_3322_1100);
      hread(5'd11, v);
      chk(v == 64'hFFEE_DDCC_BBAA_9988, "R8 in place high", v, 64'hFFEE_DDCC_BBAA_9988);
      hwrite(5'd12, 64'h0000_0001_0000_0002);
      hwrite(5'd13, 64'h0000_0003_0000_0004);
      op(mk(1'b0, 5'd12, 5'd12, 2'b10, 1'b1), 1'b0, 2, "R8");
      hread(5'd13, v);
      chk(v == 64'h0000_0004_0000_0003, "R8 32-bit high", v, 64'h0000_0004_0000_0003);
   endtask

   task automatic t_sets;
      logic [63:0] v;
      hwrite(5'd1, 64'h0102_0304_0506_0708);
      hwrite(5'd2, 64'h0);
      op(mk(1'b0, 5'd2, 5'd1, 2'b00, 1'b0), 1'b1, 0, "R1 wrong set");
      hread(5'd2, v); chk(v == 64'd0, "R1 no write on wrong set", v, 64'd0);
      op(mk(1'b1, 5'd2, 5'd1, 2'b00, 1'b0), 1'b0, 0, "R1 wrong set b");
      hread(5'd2, v); chk(v == 64'd0, "R1 no write on wrong set b", v, 64'd0);
      op(mk(1'b1, 5'd2, 5'd1, 2'b00, 1'b0), 1'b1, 1, "R1 mixed set");
      hread(5'd2, v);
      chk(v == 64'h0807_0605_0403_0201, "R1 mixed set result", v, 64'h0807_0605_0403_0201);
      op(mk(1'b0, 5'd3, 5'd1, 2'b00, 1'b0) | 32'h0000_0010, 1'b0, 0, "R1 bit4");
      hread(5'd3, v); chk(v == 64'd0, "R1 bit4 no write", v, 64'd0);
      op(mk(1'b0, 5'd3, 5'd1, 2'b00, 1'b0) | 32'h0001_0000, 1'b0, 0, "R1 bit16");
      hread(5'd3, v); chk(v == 64'd0, "R1 bit16 no write", v, 64'd0);
      op(mk(1'b0, 5'd3, 5'd1, 2'b00, 1'b0) | 32'h0000_0100, 1'b0, 0, "R1 bit8");
      hread(5'd3, v); chk(v == 64'd0, "R1 bit8 no write", v, 64'd0);
   endtask

   task automatic t_size3;
      logic [63:0] v;
      hwrite(5'd4, 64'hCAFE_F00D_1234_5678);
      op(mk(1'b0, 5'd4, 5'd1, 2'b11, 1'b0), 1'b0, 0, "R3");
      hread(5'd4, v);
      chk(v == 64'hCAFE_F00D_1234_5678, "R3 dest unchanged", v, 64'hCAFE_F00D_1234_5678);
   endtask

   task automatic t_odd;
      logic [63:0] v;
      hwrite(5'd9, 64'h9999_9999_9999_9999);
      hwrite(5'd24, 64'h2424_2424_2424_2424);
      op(mk(1'b0, 5'd9, 5'd6, 2'b00, 1'b1), 1'b0, 0, "R4 odd dest");
      hread(5'd9, v);
      chk(v == 64'h9999_9999_9999_9999, "R4 odd dest unchanged", v, 64'h9999_9999_9999_9999);
      op(mk(1'b0, 5'd24, 5'd7, 2'b00, 1'b1), 1'b0, 0, "R4 odd src");
      hread(5'd24, v);
      chk(v == 64'h2424_2424_2424_2424, "R4 odd src no write", v, 64'h2424_2424_2424_2424);
   endtask

   task automatic t_busy;
      logic [63:0] v;
      hwrite(5'd26, 64'h0123_4567_89AB_CDEF);
      hwrite(5'd28, 64'h7777_7777_7777_7777);
      @(negedge clk);
      valid_i = 1'b1; instr_i = mk(1'b0, 5'd14, 5'd6, 2'b10, 1'b1); mixed_set_i = 1'b0;
      @(negedge clk);
      instr_i = mk(1'b0, 5'd28, 5'd26, 2'b00, 1'b0);
      chk(busy_o, "R9 busy", {63'd0, busy_o}, 64'd1);
      @(negedge clk);
      @(negedge clk);
      valid_i = 1'b0;
      chk(done_o, "R9 first op done", {63'd0, done_o}, 64'd1);
      @(negedge clk);
      chk(!busy_o && !done_o, "R9 no second op", {62'd0, busy_o, done_o}, 64'd0);
      hread(5'd28, v);
      chk(v == 64'h7777_7777_7777_7777, "R9 reg28 unchanged", v, 64'h7777_7777_7777_7777);
      hread(5'd14, v);
      chk(v == 64'h3333_4444_1111_2222, "R9 first op result", v, 64'h3333_4444_1111_2222);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_host();
      t_sizes();
      t_wide();
      t_overlap();
      t_sets();
      t_size3();
      t_odd();
      t_busy();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule